// File: doc/BRIEF.md
# Triangle Linear Duration Counter

This block is a fine-resolution duration counter that decides whether a triangle waveform sequencer may advance. Software writes a setup byte that carries a hold mode bit and a 7-bit reload count. A separate strobe marks a write to the timer-high/length register, and that write arms a reload-pending flag. A periodic tick from an external frame sequencer then either reloads the counter or counts it down.

Each tick first reloads the counter if the pending flag is set, or decrements it if it is nonzero. After that, still within the same tick, the pending flag is dropped unless hold mode is on. With hold mode set, the counter reloads on every tick. The block outputs a gate that is high while the counter is nonzero. It also exports the hold mode bit, which the neighbouring length counter uses as its halt signal.

Top module: `tri_dur_gate`

## Requirements
- R1: After synchronous reset the counter, the pending flag, the hold mode bit and the reload value are all zero, so `gate_open` and `hold_mode` are 0.
- R2: A setup write stores `setup_data[7]` as the hold mode bit and `setup_data[6:0]` as the reload value. `hold_mode` shows the stored bit from the cycle after the write.
- R3: A pulse on `len_we` sets the pending flag from the next cycle.
- R4: On a tick with the pending flag set, the counter takes the reload value, including a reload value of zero.
- R5: On a tick with the pending flag clear and the counter nonzero, the counter decreases by one.
- R6: On a tick with the pending flag clear and the counter at zero, the counter stays at zero and does not wrap.
- R7: After the reload-or-decrement step of a tick, the pending flag is cleared if the hold mode bit is 0.
- R8: While the hold mode bit is 1, a tick leaves the pending flag set, so every tick reloads the counter.
- R9: `gate_open` is 1 exactly when the counter is nonzero, and follows the counter without extra delay.
- R10: When a register write and a tick fall in the same cycle, the tick uses the flag, hold mode bit and reload value from before the write, and the write takes effect afterwards.
- R11: In cycles without a tick the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_we | input | 1 | Write strobe for the setup byte |
| setup_data | input | 8 | Setup byte: bit 7 hold mode, bits 6:0 reload value |
| len_we | input | 1 | Strobe for a write to the timer-high/length register; arms a reload |
| frame_tick | input | 1 | One-cycle tick from the frame sequencer |
| hold_mode | output | 1 | Stored hold mode bit, also the length counter halt signal |
| gate_open | output | 1 | High while the duration counter is nonzero |

## Verification
The counter value is visible only through the one-bit gate, so the bench counts ticks until the gate closes. From that count it works out the loaded value and checks that each decrement was by exactly one. The hardest case to reach is a write that lands in the same cycle as a tick. The bench gets there by arming a known reload and counter state first, then raising the tick together with `len_we` or `setup_we` in one cycle. The tick count that follows shows whether the old or the new state was used.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int CNT_W   = 7;
    localparam int SETUP_W = CNT_W + 1;

    typedef struct packed {
        logic             hold;
        logic [CNT_W-1:0] reload;
    } tdc_setup_t;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DEC  = 2'd2
    } tdc_act_e;

    function automatic tdc_setup_t unpack_setup(input logic [SETUP_W-1:0] raw);
        tdc_setup_t s;
        s.hold   = raw[SETUP_W-1];
        s.reload = raw[CNT_W-1:0];
        return s;
    endfunction

    function automatic tdc_act_e pick_action(input logic tick, input logic pend,
                                             input logic nonzero);
        if (!tick)        return ACT_KEEP;
        else if (pend)    return ACT_LOAD;
        else if (nonzero) return ACT_DEC;
        else              return ACT_KEEP;
    endfunction

endpackage

// File: rtl/tdc_setup_reg.sv
module tdc_setup_reg
    import tdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SETUP_W-1:0] din,
    output tdc_setup_t         q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= unpack_setup(din);
    end
endmodule

// File: rtl/tdc_pend_flag.sv
module tdc_pend_flag (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic tick,
    input  logic hold,
    output logic pend
);
    logic nxt;

    always_comb begin
        nxt = pend;
        if (tick && !hold)
            nxt = 1'b0;
        if (arm)
            nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else
            pend <= nxt;
    end
endmodule

// File: rtl/tdc_counter.sv
module tdc_counter
    import tdc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         pend,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         nonzero
);
    tdc_act_e act;

    assign nonzero = |cnt;
    assign act     = pick_action(tick, pend, nonzero);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: cnt <= reload;
                ACT_DEC:  cnt <= cnt - W'(1);
                default:  cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/tri_dur_gate.sv
module tri_dur_gate
    import tdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               setup_we,
    input  logic [SETUP_W-1:0] setup_data,
    input  logic               len_we,
    input  logic               frame_tick,
    output logic               hold_mode,
    output logic               gate_open
);
    tdc_setup_t       setup_q;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;

    tdc_setup_reg u_setup (
        .clk (clk),
        .rst (rst),
        .we  (setup_we),
        .din (setup_data),
        .q   (setup_q)
    );

    assign hold_mode  = setup_q.hold;
    assign reload_val = setup_q.reload;

    tdc_pend_flag u_pend (
        .clk  (clk),
        .rst  (rst),
        .arm  (len_we),
        .tick (frame_tick),
        .hold (hold_mode),
        .pend (pend_q)
    );

    tdc_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (frame_tick),
        .pend    (pend_q),
        .reload  (reload_val),
        .cnt     (cnt_q),
        .nonzero (gate_open)
    );
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker
    import tdc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               setup_we,
    input logic [SETUP_W-1:0] setup_data,
    input logic               len_we,
    input logic               tick,
    input logic               hold,
    input logic               pend,
    input logic [CNT_W-1:0]   reload,
    input logic [CNT_W-1:0]   cnt
);
    a_r2_setup_store: assert property (@(posedge clk) disable iff (rst)
        setup_we |=> (hold == $past(setup_data[SETUP_W-1]) &&
                      reload == $past(setup_data[CNT_W-1:0])));

    a_r3_arm_pending: assert property (@(posedge clk) disable iff (rst)
        len_we |=> pend);

    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && pend) |=> cnt == $past(reload));

    a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick && !pend && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !pend && cnt == '0) |=> cnt == '0);

    a_r7_pend_clear: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !len_we) |=> !pend);

    a_r8_pend_keep: assert property (@(posedge clk) disable iff (rst)
        (pend && hold) |=> pend);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
endmodule

bind tri_dur_gate tdc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .setup_we   (setup_we),
    .setup_data (setup_data),
    .len_we     (len_we),
    .tick       (frame_tick),
    .hold       (hold_mode),
    .pend       (pend_q),
    .reload     (reload_val),
    .cnt        (cnt_q)
);

// File: tb/tri_dur_gate_test.sv
module tri_dur_gate_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       setup_we;
    logic [7:0] setup_data;
    logic       len_we;
    logic       frame_tick;
    logic       hold_mode;
    logic       gate_open;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_dur_gate uut (
        .clk        (clk),
        .rst        (rst),
        .setup_we   (setup_we),
        .setup_data (setup_data),
        .len_we     (len_we),
        .frame_tick (frame_tick),
        .hold_mode  (hold_mode),
        .gate_open  (gate_open)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // One clock cycle with the given strobes; results sampled 1 ns after the edge.
    task automatic step(input logic sw, input logic [7:0] sd, input logic lw,
                        input logic tk);
        setup_we = sw; setup_data = sd; len_we = lw; frame_tick = tk;
        @(posedge clk);
        #1;
        setup_we = 1'b0; len_we = 1'b0; frame_tick = 1'b0;
    endtask

    task automatic tick();
        step(1'b0, 8'h00, 1'b0, 1'b1);
    endtask

    // Arm and load: setup write, length write, tick.
    task automatic load(input logic h, input logic [6:0] n);
        step(1'b1, {h, n}, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; setup_we = 0; setup_data = 0; len_we = 0; frame_tick = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 gate after reset", gate_open, 1'b0);
        check("R1 hold after reset", hold_mode, 1'b0);
        tick();
        check("R6 tick from zero, no reload", gate_open, 1'b0);
    endtask

    task automatic t_count_down();
        load(1'b0, 7'd5);
        check("R2 hold bit stored 0", hold_mode, 1'b0);
        check("R4 R9 reload 5 opens gate", gate_open, 1'b1);
        for (int i = 1; i < 5; i++) begin
            tick();
            check("R5 gate open while counting", gate_open, 1'b1);
        end
        tick();
        check("R5 R9 gate closes after 5 ticks", gate_open, 1'b0);
        tick(); tick();
        check("R6 R7 stays zero, no re-reload", gate_open, 1'b0);
    endtask

    task automatic t_idle();
        load(1'b0, 7'd1);
        check("R4 reload 1", gate_open, 1'b1);
        repeat (20) step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R11 no tick keeps count", gate_open, 1'b1);
        tick();
        check("R5 single decrement to zero", gate_open, 1'b0);
    endtask

    task automatic t_hold_mode();
        load(1'b1, 7'd2);
        check("R2 hold bit stored 1", hold_mode, 1'b1);
        for (int i = 0; i < 6; i++) tick();
        check("R8 reload each tick keeps gate open", gate_open, 1'b1);
        step(1'b1, 8'h02, 1'b0, 1'b0);
        check("R2 hold bit cleared", hold_mode, 1'b0);
        tick();
        tick();
        check("R7 pend cleared, count 1", gate_open, 1'b1);
        tick();
        check("R7 count reaches zero", gate_open, 1'b0);
    endtask

    task automatic t_zero_reload();
        load(1'b0, 7'd3);
        load(1'b0, 7'd0);
        check("R4 reload of zero closes gate", gate_open, 1'b0);
    endtask

    task automatic t_same_cycle();
        // Counter zero, flag clear: arm and tick together; tick must see old flag.
        step(1'b1, 8'h03, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b1);
        check("R10 tick ignores same-cycle arm", gate_open, 1'b0);
        // New setup in same cycle as the reloading tick: old value 3 loads.
        step(1'b1, 8'h06, 1'b0, 1'b1);
        check("R10 reload uses pre-write value", gate_open, 1'b1);
        tick(); tick();
        check("R10 count 1 after two ticks", gate_open, 1'b1);
        tick();
        check("R10 loaded value was 3", gate_open, 1'b0);
        // Hold bit old=1 while tick writes hold=0: flag must survive that tick.
        step(1'b1, 8'h84, 1'b1, 1'b0);
        step(1'b1, 8'h02, 1'b0, 1'b1);
        check("R10 old hold keeps flag", gate_open, 1'b1);
        tick();
        tick();
        check("R10 reloaded 2 then count 1", gate_open, 1'b1);
        tick();
        check("R10 count reaches zero", gate_open, 1'b0);
    endtask

    initial begin
        t_reset();
        t_count_down();
        t_idle();
        t_hold_mode();
        t_zero_reload();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule